// File: doc/BRIEF.md
# Lockable Secure-Memory Window Guard

The block guards one window of on-chip secure memory. Software describes the window through a small bank of 32-bit registers. The start address is a 4 KB page number, split between a low word and a high word, and forms a 34-bit physical address. The length is given as a number of whole 128 KB blocks plus a number of extra 4 KB pages, both held in a single word. Six permission words hold a read bit and a write bit for each client. Six further words are reserved for forced internal routing; software can write them, read them back and lock them.

Each memory request carries a client number, a 34-bit address and a read/write flag. One cycle later the block returns allow or deny. A request inside the window is allowed only if that client holds the right for the direction of the request. A request outside the window is always allowed. A denied request inside the window also raises a one-cycle violation pulse.

Setting the lock bit in the configuration word freezes every register until reset. This guards the setup against later tampering.

Top module: `carve_guard`

## Requirements
- R1: After a synchronous active-low reset, every register word reads zero and `rsp_valid`, `rsp_allow` and `rsp_violation` are low.
- R2: Word 1 keeps address bits 31:12 in its bits 31:12, and its bits 11:0 read zero. Word 2 keeps address bits 33:32 in its bits 1:0, and all its other bits read zero.
- R3: Word 3 holds two counts. Bits 16:0 give the number of 128 KB blocks. Bits 31:27 give the number of additional 4 KB pages. Bits 26:17 read zero. The window length is the sum of the two amounts.
- R4: A request falls inside the window when start <= address < start + length, comparing all 34 bits. A window of length zero matches no address.
- R5: A request outside the window is always allowed and never raises a violation.
- R6: Client number 14k+j, with k from 0 to 5 and j from 0 to 13, takes its read right from bit j of word 4+k and its write right from bit 18+j of that word. The CPU is client 21, which uses bit 7 (read) and bit 25 (write) of word 5. A request inside the window is allowed only if the right matching its direction is set.
- R7: A denied request inside the window gives `rsp_valid`=1, `rsp_allow`=0 and `rsp_violation`=1 for exactly one cycle per request.
- R8: Word 0 holds two bits. Bit 1 is the lock. Bit 0 is a secure-only flag that software can read back, and the same write that sets the lock can clear it. Once the lock is set, every write to words 0 to 15 is ignored until reset.
- R9: Register read data appears one cycle after `rd_en`. The response to a request appears one cycle after `req_valid`, and there is no response in cycles without a request.
- R10: Client numbers 84 and above have no rights, so any request they make inside the window is denied.
- R11: Words 10 to 15 store all 32 bits that are written, read them back, and are frozen by the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address for write |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register word address for read |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| req_valid | input | 1 | Memory request present |
| req_client | input | 7 | Requesting client number |
| req_addr | input | 34 | Request physical byte address |
| req_write | input | 1 | 1 = write request, 0 = read request |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_allow | output | 1 | Request allowed |
| rsp_violation | output | 1 | Denied access inside the window |

## Verification
Requests are aimed at the first byte of the window, the last byte, one byte below the start and the first byte past the end. These four probes separate an inclusive start from an exclusive end and catch off-by-one errors at either edge. Writes are also sent to an address that differs from the start only in the high word, which shows whether bits 33:32 take part in the compare. A length made only of 4 KB pages and a length of zero show whether the two counts are summed correctly and whether an empty window stays empty. The permission tests use the CPU, the first client, the last client and an out-of-range client, each with only one right granted, so that a swapped read/write bit or a wrong client mapping gives a visible mismatch. The lock test writes new values to every kind of word after locking, then reads them back and repeats the requests.

// File: rtl/carve_pkg.sv
// Package: shared sizes, field positions and word addresses for the
// secure-memory window guard. Assumes a 34-bit physical space and 4 KB pages.
package carve_pkg;
    localparam int REG_W    = 32;
    localparam int RADDR_W  = 4;
    localparam int PA_W     = 34;
    localparam int PAGE_SH  = 12;
    localparam int BLK_SH   = 17;
    localparam int PG_W     = PA_W - PAGE_SH;        // page-number width
    localparam int BLO_W    = REG_W - PAGE_SH;       // low start field width
    localparam int BHI_W    = PA_W - REG_W;          // high start field width
    localparam int RES_W    = BLK_SH - PAGE_SH;      // pages per block, log2
    localparam int RES_POS  = REG_W - RES_W;         // residual page field position
    localparam int BLK_W    = PG_W - RES_W;          // block count width
    localparam int N_ACC    = 6;
    localparam int CL_PER   = 14;
    localparam int WR_OFS   = 18;
    localparam int N_CLIENT = N_ACC * CL_PER;
    localparam int CID_W    = 7;
    localparam int CL_SPAN  = 1 << CID_W;
    localparam int LOCK_BIT = 1;
    localparam int SEC_BIT  = 0;

    localparam logic [RADDR_W-1:0] A_CFG  = 4'd0;
    localparam logic [RADDR_W-1:0] A_BLO  = 4'd1;
    localparam logic [RADDR_W-1:0] A_BHI  = 4'd2;
    localparam logic [RADDR_W-1:0] A_SIZE = 4'd3;
    localparam int                 A_ACC0 = 4;
    localparam int                 A_FRC0 = A_ACC0 + N_ACC;
endpackage

// File: rtl/carve_regs.sv
// Module: register bank with a sticky lock. Holds configuration, window
// start, window length, permission and forced-routing words. Assumes
// one write and one read port; read data is registered.
module carve_regs
    import carve_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RADDR_W-1:0]       wr_addr,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     rd_en,
    input  logic [RADDR_W-1:0]       rd_addr,
    output logic [REG_W-1:0]         rd_data,
    output logic [PG_W-1:0]          base_page,
    output logic [BLK_W-1:0]         size_blk,
    output logic [RES_W-1:0]         size_res,
    output logic [N_ACC*REG_W-1:0]   acc_flat,
    output logic                     locked
);
    logic [1:0]        cfg_q;
    logic [BLO_W-1:0]  blo_q;
    logic [BHI_W-1:0]  bhi_q;
    logic [BLK_W-1:0]  sblk_q;
    logic [RES_W-1:0]  sres_q;
    logic [REG_W-1:0]  acc_q [N_ACC];
    logic [REG_W-1:0]  frc_q [N_ACC];
    logic              wr_ok;
    logic [REG_W-1:0]  rd_c;

    assign wr_ok = wr_en && !cfg_q[LOCK_BIT];

    // Purpose: configuration, start and length words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            blo_q  <= '0;
            bhi_q  <= '0;
            sblk_q <= '0;
            sres_q <= '0;
        end else if (wr_ok) begin
            case (wr_addr)
                A_CFG:  cfg_q  <= wr_data[1:0];
                A_BLO:  blo_q  <= wr_data[REG_W-1:PAGE_SH];
                A_BHI:  bhi_q  <= wr_data[BHI_W-1:0];
                A_SIZE: begin
                    sblk_q <= wr_data[BLK_W-1:0];
                    sres_q <= wr_data[REG_W-1:RES_POS];
                end
                default: ;
            endcase
        end
    end

    // Purpose: permission and forced-routing words, one pair per index.
    for (genvar k = 0; k < N_ACC; k++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[k] <= '0;
                frc_q[k] <= '0;
            end else if (wr_ok) begin
                if (wr_addr == RADDR_W'(A_ACC0 + k)) acc_q[k] <= wr_data;
                if (wr_addr == RADDR_W'(A_FRC0 + k)) frc_q[k] <= wr_data;
            end
        end
        assign acc_flat[k*REG_W +: REG_W] = acc_q[k];
    end

    // Purpose: read multiplexer.
    always_comb begin
        rd_c = '0;
        case (rd_addr)
            A_CFG:  rd_c = {{(REG_W-2){1'b0}}, cfg_q};
            A_BLO:  rd_c = {blo_q, {PAGE_SH{1'b0}}};
            A_BHI:  rd_c = {{(REG_W-BHI_W){1'b0}}, bhi_q};
            A_SIZE: rd_c = {sres_q, {(REG_W-RES_W-BLK_W){1'b0}}, sblk_q};
            default: ;
        endcase
        for (int k = 0; k < N_ACC; k++) begin
            if (rd_addr == RADDR_W'(A_ACC0 + k)) rd_c = acc_q[k];
            if (rd_addr == RADDR_W'(A_FRC0 + k)) rd_c = frc_q[k];
        end
    end

    // Purpose: one-cycle registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_c;
    end

    assign base_page = {bhi_q, blo_q};
    assign size_blk  = sblk_q;
    assign size_res  = sres_q;
    assign locked    = cfg_q[LOCK_BIT];
endmodule

// File: rtl/carve_window.sv
// Module: window decode and range compare. Works in 4 KB page units.
// Assumes the start is page aligned, so a page compare equals a byte compare.
module carve_window
    import carve_pkg::*;
(
    input  logic [PG_W-1:0]  base_page,
    input  logic [BLK_W-1:0] size_blk,
    input  logic [RES_W-1:0] size_res,
    input  logic [PA_W-1:0]  req_addr,
    output logic             hit
);
    logic [PG_W-1:0] req_page;
    logic [PG_W-1:0] len_pages;
    logic [PG_W:0]   end_page;

    // Purpose: length in pages, exclusive end, and the inside test.
    always_comb begin
        req_page  = req_addr[PA_W-1:PAGE_SH];
        len_pages = {size_blk, {RES_W{1'b0}}} + PG_W'(size_res);
        end_page  = {1'b0, base_page} + {1'b0, len_pages};
        hit       = (req_page >= base_page) && ({1'b0, req_page} < end_page);
    end
endmodule

// File: rtl/carve_perm.sv
// Module: per-client permission lookup. Unpacks the permission words into
// read and write vectors over the whole client-number range; numbers
// past the last client get no rights.
module carve_perm
    import carve_pkg::*;
(
    input  logic [N_ACC*REG_W-1:0] acc_flat,
    input  logic [CID_W-1:0]       client,
    input  logic                   is_write,
    output logic                   granted
);
    logic [CL_SPAN-1:0] rd_vec;
    logic [CL_SPAN-1:0] wr_vec;

    for (genvar c = 0; c < CL_SPAN; c++) begin : g_cl
        if (c < N_CLIENT) begin : g_real
            assign rd_vec[c] = acc_flat[(c / CL_PER)*REG_W + (c % CL_PER)];
            assign wr_vec[c] = acc_flat[(c / CL_PER)*REG_W + WR_OFS + (c % CL_PER)];
        end else begin : g_none
            assign rd_vec[c] = 1'b0;
            assign wr_vec[c] = 1'b0;
        end
    end

    // Purpose: pick the right that matches the request direction.
    always_comb granted = is_write ? wr_vec[client] : rd_vec[client];
endmodule

// File: rtl/carve_guard.sv
// Module: top of the secure-memory window guard. Joins the register bank,
// window compare and permission lookup, and registers the allow/deny
// result one cycle after each request.
module carve_guard
    import carve_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 rd_en,
    input  logic [RADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 req_valid,
    input  logic [CID_W-1:0]     req_client,
    input  logic [PA_W-1:0]      req_addr,
    input  logic                 req_write,
    output logic                 rsp_valid,
    output logic                 rsp_allow,
    output logic                 rsp_violation
);
    logic [PG_W-1:0]        base_page;
    logic [BLK_W-1:0]       size_blk;
    logic [RES_W-1:0]       size_res;
    logic [N_ACC*REG_W-1:0] acc_flat;
    logic                   locked;
    logic                   win_hit;
    logic                   granted;

    carve_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .base_page(base_page), .size_blk(size_blk), .size_res(size_res),
        .acc_flat(acc_flat), .locked(locked)
    );

    carve_window u_win (
        .base_page(base_page), .size_blk(size_blk), .size_res(size_res),
        .req_addr(req_addr), .hit(win_hit)
    );

    carve_perm u_perm (
        .acc_flat(acc_flat), .client(req_client),
        .is_write(req_write), .granted(granted)
    );

    // Purpose: registered response, violation only on a denied hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_allow     <= 1'b0;
            rsp_violation <= 1'b0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_allow     <= req_valid && (!win_hit || granted);
            rsp_violation <= req_valid && win_hit && !granted;
        end
    end
endmodule

// File: rtl/carve_guard_chk.sv
// Module: property checker for the window guard, attached by bind.
module carve_guard_chk
    import carve_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [PA_W-1:0]        req_addr,
    input logic                   rsp_valid,
    input logic                   rsp_allow,
    input logic                   rsp_violation,
    input logic                   locked,
    input logic                   win_hit,
    input logic [PG_W-1:0]        base_page,
    input logic [BLK_W-1:0]       size_blk,
    input logic [RES_W-1:0]       size_res,
    input logic [N_ACC*REG_W-1:0] acc_flat
);
    a_r7_violation_is_deny: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_violation |-> (rsp_valid && !rsp_allow));

    a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_allow && !rsp_violation));

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(base_page) && $stable(size_blk) &&
                    $stable(size_res) && $stable(acc_flat)));

    a_r4_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (size_blk == '0 && size_res == '0) |-> !win_hit);

    a_r4_not_below_start: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (req_addr[PA_W-1:PAGE_SH] >= base_page));

    a_r5_miss_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !win_hit) |=> (rsp_allow && !rsp_violation));
endmodule

bind carve_guard carve_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_violation(rsp_violation),
    .locked(locked), .win_hit(win_hit), .base_page(base_page),
    .size_blk(size_blk), .size_res(size_res), .acc_flat(acc_flat)
);

// File: tb/carve_guard_bench.sv
// Directed bench for the window guard: one task per scenario.
module carve_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        req_valid = 1'b0;
    logic [6:0]  req_client = '0;
    logic [33:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_allow, rsp_violation;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam logic [33:0] BASE = 34'h1_3000_0000;

    carve_guard u_carve_guard (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .req_valid(req_valid), .req_client(req_client),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_violation(rsp_violation)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, 64'(rd_data), 64'(exp));
    endtask

    // Issues one request, checks the response a cycle later and the idle cycle after.
    task automatic req_chk(input string tag, input int cl, input logic [33:0] a,
                           input bit w, input bit exp_allow);
        @(negedge clk);
        req_valid = 1'b1; req_client = 7'(cl); req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {61'd0, rsp_valid, rsp_allow, rsp_violation},
              {61'd0, 1'b1, exp_allow, !exp_allow});
        @(negedge clk);
        check({tag, " idle"}, {61'd0, rsp_valid, rsp_allow, rsp_violation}, 64'd0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 outputs after reset", {61'd0, rsp_valid, rsp_allow, rsp_violation}, 64'd0);
        for (int a = 0; a < 16; a++) rd_chk("R1 word zero after reset", a, 32'd0);
    endtask

    task automatic t_fields();
        wr(1, 32'hFFFF_FFFF); rd_chk("R2 low start field", 1, 32'hFFFF_F000);
        wr(2, 32'hFFFF_FFFF); rd_chk("R2 high start field", 2, 32'h0000_0003);
        wr(3, 32'hFFFF_FFFF); rd_chk("R3 length fields", 3, 32'hF801_FFFF);
        wr(0, 32'hFFFF_FFFD); rd_chk("R8 secure-only flag", 0, 32'h0000_0001);
        wr(0, 32'h0);
        wr(10, 32'hA5A5_5A5A); rd_chk("R11 forced word 10", 10, 32'hA5A5_5A5A);
        wr(15, 32'h1234_8765); rd_chk("R11 forced word 15", 15, 32'h1234_8765);
        @(negedge clk); rd_en = 1'b1; rd_addr = 4'd15;
        @(posedge clk); #1;
        check("R9 read data after one edge", 64'(rd_data), 64'h1234_8765);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_window();
        // start 0x1_3000_0000, length 2 blocks + 3 pages = 0x43000
        wr(1, 32'h3000_0000); wr(2, 32'h1);
        wr(3, (32'd3 << 27) | 32'd2);
        wr(5, 32'h1 << 7);            // CPU read only
        req_chk("R6 cpu read at start", 21, BASE, 1'b0, 1'b1);
        req_chk("R6 cpu write at start denied", 21, BASE, 1'b1, 1'b0);
        req_chk("R4 last byte inside", 21, BASE + 34'h42FFF, 1'b1, 1'b0);
        req_chk("R5 first byte past end", 21, BASE + 34'h43000, 1'b1, 1'b1);
        req_chk("R5 byte below start", 21, BASE - 34'd1, 1'b1, 1'b1);
        req_chk("R4 high bits compared", 21, 34'h0_3000_0000, 1'b1, 1'b1);
        req_chk("R7 client without rights", 0, BASE, 1'b0, 1'b0);
        wr(4, 32'h1 << 18);           // client 0 write only
        req_chk("R6 client0 write", 0, BASE + 34'h100, 1'b1, 1'b1);
        req_chk("R6 client0 read denied", 0, BASE + 34'h100, 1'b0, 1'b0);
        wr(9, 32'h1 << 13);           // client 83 read only
        req_chk("R6 client83 read", 83, BASE, 1'b0, 1'b1);
        req_chk("R6 client83 write denied", 83, BASE, 1'b1, 1'b0);
        wr(5, 32'hFFFF_FFFF);
        req_chk("R10 client 90 denied", 90, BASE, 1'b0, 1'b0);
        req_chk("R6 cpu write with bit 25", 21, BASE, 1'b1, 1'b1);
        wr(5, 32'h1 << 7);
        // back-to-back denied requests: one pulse each
        @(negedge clk);
        req_valid = 1'b1; req_client = 7'd21; req_addr = BASE; req_write = 1'b1;
        @(negedge clk);
        req_addr = BASE - 34'd1;
        check("R7 first of pair denied", {62'd0, rsp_allow, rsp_violation}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 pulse ends on miss", {61'd0, rsp_valid, rsp_allow, rsp_violation}, 64'd6);
        @(negedge clk);
    endtask

    task automatic t_sizes();
        wr(3, 32'd1 << 27);           // one page only
        req_chk("R3 page-only length inside", 21, BASE + 34'hFFF, 1'b1, 1'b0);
        req_chk("R3 page-only length end", 21, BASE + 34'h1000, 1'b1, 1'b1);
        wr(3, 32'd1);                 // one block only
        req_chk("R3 block-only last byte", 21, BASE + 34'h1FFFF, 1'b1, 1'b0);
        req_chk("R3 block-only end", 21, BASE + 34'h20000, 1'b1, 1'b1);
        wr(3, 32'd0);
        req_chk("R4 zero length matches nothing", 21, BASE, 1'b1, 1'b1);
    endtask

    task automatic t_lock();
        wr(3, (32'd3 << 27) | 32'd2);
        wr(12, 32'hCAFE_0001);
        wr(0, 32'h2);                 // lock, secure-only flag cleared
        rd_chk("R8 lock set", 0, 32'h2);
        wr(0, 32'h1); rd_chk("R8 config frozen", 0, 32'h2);
        wr(1, 32'h0); rd_chk("R8 low start frozen", 1, 32'h3000_0000);
        wr(2, 32'h0); rd_chk("R8 high start frozen", 2, 32'h1);
        wr(3, 32'h0); rd_chk("R8 length frozen", 3, (32'd3 << 27) | 32'd2);
        wr(5, 32'hFFFF_FFFF); rd_chk("R8 permission frozen", 5, 32'h1 << 7);
        wr(12, 32'h0); rd_chk("R11 forced word frozen", 12, 32'hCAFE_0001);
        req_chk("R8 locked write still denied", 21, BASE, 1'b1, 1'b0);
        req_chk("R8 locked read still allowed", 21, BASE, 1'b0, 1'b1);
        do_reset();
        rd_chk("R1 lock cleared by reset", 0, 32'h0);
        wr(1, 32'h0000_5000); rd_chk("R8 writable after reset", 1, 32'h0000_5000);
    endtask

    initial begin
        t_reset();
        t_fields();
        t_window();
        t_sizes();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule